// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block turns a programmed SDRAM mode word and a starting column into the column address sequence of one read or write burst, one address per clock. A memory controller pulses the start input with the starting column and a read/write flag. The sequencer then outputs a column address on each beat, together with a valid strobe. A last flag marks the final beat, and a done pulse follows one cycle later. Command timing, CAS delay, refresh, bank handling and data movement belong to the controller around it.

The mode word sets the burst length (1, 2, 4, 8 or a whole row), the ordering inside a block (sequential wrap or interleaved XOR) and whether write bursts collapse to one column. The block decodes the word continuously and raises a flag whenever the word uses a reserved code. A burst keeps the mode word, the start column and the read/write flag that were present when it began. A terminate input ends any burst early, and is the only way to end a whole-row burst.

Top module: `burst_col_seq`

## Requirements
- R1: Mode word fields: length code in bits [2:0] (000=1, 001=2, 010=4, 011=8, 111=whole row of 2^COL_W columns); order select in bit 3 (0 sequential, 1 interleaved); CAS code in bits [6:4]; operating mode in bits [8:7]; write-single in bit 9; bits [12:10] must be zero.
- R2: A start pulse is accepted while colValid is low. The first beat appears in the cycle after the sampling edge, with colValid high and colAddr equal to the start column. A new beat follows on every cycle after that.
- R3: In sequential order, for lengths 2, 4 and 8, the address counts up from the start column. It wraps to the bottom of the aligned block that holds the start column, and the upper bits never change.
- R4: In interleaved order, the low log2(length) bits of beat k equal the start column's low bits XOR k, and the upper bits stay fixed.
- R5: With length code 000, exactly one beat is issued at the start column, and the order bit has no effect.
- R6: A whole-row burst counts upward and wraps from the top column to column 0. It never raises lastBeat and keeps running until terminate.
- R7: With write-single set, a write burst issues one beat at the start column. A read burst with write-single set still uses the programmed length.
- R8: lastBeat is high only together with colValid on the final beat of a non-whole-row burst. In the next cycle colValid is low and burstDone is high for exactly one cycle.
- R9: If terminate is high during a valid beat, colValid is low in the next cycle and burstDone is high. Terminate while idle has no effect.
- R10: A start pulse during an active burst is ignored. Changes to modeWord, startCol or isWrite during a burst do not alter its addresses or its length.
- R11: modeIllegal is high, combinationally from modeWord, for any of these: length code 100, 101 or 110; CAS code outside 1 to 3; nonzero operating mode; nonzero bits [12:10]; interleaved order with whole-row length. A start pulse with such a word is refused: no beat and no done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| modeWord | input | 13 | Programmed mode word |
| startPulse | input | 1 | Request to begin a burst |
| startCol | input | COL_W | Starting column of the burst |
| isWrite | input | 1 | 1 for a write burst, 0 for a read |
| terminate | input | 1 | Ends the current burst after this beat |
| colValid | output | 1 | colAddr holds a beat of the burst |
| colAddr | output | COL_W | Column address of the current beat |
| lastBeat | output | 1 | Final beat of a fixed-length burst |
| burstDone | output | 1 | One-cycle pulse after a burst ends |
| modeIllegal | output | 1 | Mode word uses a reserved code |

## Verification
A natural final beat and a terminate request can fall in the same cycle. Both would end the burst. The bench raises terminate exactly on the last beat of a length-4 burst and expects the following: lastBeat is still shown on that beat, no extra address is issued, and burstDone pulses once and only once. A second collision is a start pulse that arrives mid-burst while the mode word, column and direction are all changed at the same time. It is judged by the original burst running to its own length with its original addresses.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

  localparam int MODE_W = 13;

  // mode word field positions
  localparam int LEN_LO  = 0;
  localparam int ORD_BIT = 3;
  localparam int CAS_LO  = 4;
  localparam int OPM_LO  = 7;
  localparam int WSG_BIT = 9;
  localparam int RSV_LO  = 10;

  // length codes
  localparam logic [2:0] LEN_ONE   = 3'b000;
  localparam logic [2:0] LEN_TWO   = 3'b001;
  localparam logic [2:0] LEN_FOUR  = 3'b010;
  localparam logic [2:0] LEN_EIGHT = 3'b011;
  localparam logic [2:0] LEN_ROW   = 3'b111;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic advance;
    logic finish;
  } seqStrobe_t;

  function automatic logic modeReserved(input logic [MODE_W-1:0] mw);
    logic [2:0] lenCode;
    logic [2:0] casCode;
    logic lenOk;
    logic casOk;
    lenCode = mw[LEN_LO +: 3];
    casCode = mw[CAS_LO +: 3];
    lenOk = (lenCode == LEN_ONE) || (lenCode == LEN_TWO) || (lenCode == LEN_FOUR) ||
            (lenCode == LEN_EIGHT) || (lenCode == LEN_ROW);
    casOk = (casCode == 3'd1) || (casCode == 3'd2) || (casCode == 3'd3);
    return !lenOk || !casOk || (mw[OPM_LO +: 2] != 2'b00) || (mw[RSV_LO +: 3] != 3'b000) ||
           (mw[ORD_BIT] && (lenCode == LEN_ROW));
  endfunction

endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_col_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       modeIllegal,
  input  logic       terminate,
  input  logic       atLast,
  output seqStrobe_t strobe,
  output logic       busy,
  output logic       doneOut
);

  always_comb begin
    strobe.load    = !busy && startPulse && !modeIllegal;
    strobe.advance = busy && !terminate && !atLast;
    strobe.finish  = busy && (terminate || atLast);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      doneOut <= 1'b0;
    end else begin
      if (strobe.load)        busy <= 1'b1;
      else if (strobe.finish) busy <= 1'b0;
      doneOut <= strobe.finish;
    end
  end

  p_done_after_last_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy && atLast |=> doneOut && !busy);

  p_done_one_cycle_r8: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);

  p_term_ends_r9: assert property (@(posedge clk) disable iff (!rstN)
    busy && terminate |=> !busy && doneOut);

  p_busy_holds_r10: assert property (@(posedge clk) disable iff (!rstN)
    busy && !terminate && !atLast |=> busy);

  p_illegal_refused_r11: assert property (@(posedge clk) disable iff (!rstN)
    !busy && modeIllegal |=> !busy);

endmodule

// File: rtl/burst_seq_dp.sv
module burst_seq_dp
  import burst_col_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic             running,
  input  logic [COL_W-1:0] startCol,
  input  logic [COL_W-1:0] blkMask,
  input  logic             fullRow,
  input  logic             interleave,
  output logic [COL_W-1:0] colAddr,
  output logic             atLast
);

  logic [COL_W-1:0] baseCol;
  logic [COL_W-1:0] maskReg;
  logic [COL_W-1:0] beatIdx;
  logic             fullReg;
  logic             ilvReg;
  logic [COL_W-1:0] offset;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseCol <= '0;
      maskReg <= '0;
      beatIdx <= '0;
      fullReg <= 1'b0;
      ilvReg  <= 1'b0;
    end else if (strobe.load) begin
      baseCol <= startCol;
      maskReg <= blkMask;
      beatIdx <= '0;
      fullReg <= fullRow;
      ilvReg  <= interleave;
    end else if (strobe.advance) begin
      beatIdx <= beatIdx + 1'b1;
    end
  end

  always_comb begin
    offset  = ilvReg ? (baseCol ^ beatIdx) : (baseCol + beatIdx);
    colAddr = (baseCol & ~maskReg) | (offset & maskReg);
    atLast  = !fullReg && (beatIdx == maskReg);
  end

  p_seq_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    running && $past(running) && !ilvReg && (maskReg != '0)
      |-> ((colAddr - $past(colAddr)) & maskReg) == COL_W'(1));

  p_block_kept_r4: assert property (@(posedge clk) disable iff (!rstN)
    running && $past(running) |-> ((colAddr ^ $past(colAddr)) & ~maskReg) == '0);

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_col_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [12:0]      modeWord,
  input  logic             startPulse,
  input  logic [COL_W-1:0] startCol,
  input  logic             isWrite,
  input  logic             terminate,
  output logic             colValid,
  output logic [COL_W-1:0] colAddr,
  output logic             lastBeat,
  output logic             burstDone,
  output logic             modeIllegal
);

  localparam logic [COL_W-1:0] ROW_MASK = {COL_W{1'b1}};

  seqStrobe_t       strobe;
  logic             busy;
  logic             atLast;
  logic [COL_W-1:0] blkMask;
  logic             fullRow;

  always_comb begin
    modeIllegal = modeReserved(modeWord);
    fullRow     = 1'b0;
    blkMask     = '0;
    if (!(isWrite && modeWord[WSG_BIT])) begin
      unique case (modeWord[LEN_LO +: 3])
        LEN_TWO:   blkMask = COL_W'(1);
        LEN_FOUR:  blkMask = COL_W'(3);
        LEN_EIGHT: blkMask = COL_W'(7);
        LEN_ROW: begin
          blkMask = ROW_MASK;
          fullRow = 1'b1;
        end
        default:   blkMask = '0;
      endcase
    end
  end

  burst_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .modeIllegal(modeIllegal),
    .terminate  (terminate),
    .atLast     (atLast),
    .strobe     (strobe),
    .busy       (busy),
    .doneOut    (burstDone)
  );

  burst_seq_dp #(.COL_W(COL_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .running   (busy),
    .startCol  (startCol),
    .blkMask   (blkMask),
    .fullRow   (fullRow),
    .interleave(modeWord[ORD_BIT]),
    .colAddr   (colAddr),
    .atLast    (atLast)
  );

  assign colValid = busy;
  assign lastBeat = busy && atLast;

  p_last_with_valid_r8: assert property (@(posedge clk) disable iff (!rstN)
    lastBeat |-> colValid);

endmodule

// File: tb/test_burst_col_seq.sv
module test_burst_col_seq;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [12:0] modeWord = '0;
  logic        startPulse = 1'b0;
  logic [8:0]  startCol = '0;
  logic        isWrite = 1'b0;
  logic        terminate = 1'b0;
  logic        colValid;
  logic [8:0]  colAddr;
  logic        lastBeat;
  logic        burstDone;
  logic        modeIllegal;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  burst_col_seq i_burst_col_seq (
    .clk(clk), .rstN(rstN), .modeWord(modeWord), .startPulse(startPulse),
    .startCol(startCol), .isWrite(isWrite), .terminate(terminate),
    .colValid(colValid), .colAddr(colAddr), .lastBeat(lastBeat),
    .burstDone(burstDone), .modeIllegal(modeIllegal)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [12:0] mk(input int lenc, input int ord, input int wsg);
    return {3'b000, 1'(wsg), 2'b00, 3'd2, 1'(ord), 3'(lenc)};
  endfunction

  function automatic int expCol(input int sc, input int blk, input bit ilv, input int k);
    int base;
    int low;
    if (blk == 1) return sc;
    base = sc - (sc % blk);
    low  = sc % blk;
    if (ilv) return base + (low ^ k);
    return base + ((low + k) % blk);
  endfunction

  // blk: effective beats of the burst, termAt: beat carrying terminate (-1 none)
  task automatic doBurst(input logic [12:0] mw, input int sc, input bit wr, input int blk,
                         input bit ilv, input int termAt, input bit disturb, input string req);
    int nBeats;
    nBeats = (termAt >= 0) ? termAt + 1 : blk;
    @(negedge clk);
    modeWord = mw; startCol = 9'(sc); isWrite = wr; startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    for (int k = 0; k < nBeats; k++) begin
      check(colValid === 1'b1, req, int'(colValid), 1);
      check(int'(colAddr) == expCol(sc, blk, ilv, k), req, int'(colAddr), expCol(sc, blk, ilv, k));
      check(lastBeat === ((k == blk - 1) && blk < 512), req, int'(lastBeat),
            int'((k == blk - 1) && blk < 512));
      check(burstDone === 1'b0, req, int'(burstDone), 0);
      if (termAt == k) terminate = 1'b1;
      if (disturb && k == 1) begin
        startPulse = 1'b1;
        startCol   = ~startCol;
        modeWord   = mk(1, 0, 1);
        isWrite    = ~wr;
      end
      @(negedge clk);
      terminate = 1'b0; startPulse = 1'b0;
    end
    check(colValid === 1'b0, req, int'(colValid), 0);
    check(burstDone === 1'b1, req, int'(burstDone), 1);
    @(negedge clk);
    check(burstDone === 1'b0, req, int'(burstDone), 0);
    check(colValid === 1'b0, req, int'(colValid), 0);
  endtask

  task automatic testReset();
    check(colValid === 1'b0, "R2 reset valid", int'(colValid), 0);
    check(lastBeat === 1'b0, "R8 reset last", int'(lastBeat), 0);
    check(burstDone === 1'b0, "R8 reset done", int'(burstDone), 0);
  endtask

  task automatic testSequential();
    doBurst(mk(3, 0, 0), 9'h0AD, 1'b0, 8, 1'b0, -1, 1'b0, "R3 R2 seq len8");
    doBurst(mk(2, 0, 0), 9'h133, 1'b0, 4, 1'b0, -1, 1'b0, "R3 R1 seq len4");
    doBurst(mk(1, 0, 0), 9'h0F1, 1'b1, 2, 1'b0, -1, 1'b0, "R3 seq len2");
  endtask

  task automatic testInterleaved();
    doBurst(mk(3, 1, 0), 9'h005, 1'b0, 8, 1'b1, -1, 1'b0, "R4 ilv len8");
    doBurst(mk(2, 1, 0), 9'h1FE, 1'b0, 4, 1'b1, -1, 1'b0, "R4 ilv len4");
    doBurst(mk(1, 1, 0), 9'h041, 1'b0, 2, 1'b1, -1, 1'b0, "R4 ilv len2");
  endtask

  task automatic testSingle();
    doBurst(mk(0, 1, 0), 9'h17B, 1'b0, 1, 1'b1, -1, 1'b0, "R5 len1 order ignored");
    doBurst(mk(0, 0, 0), 9'h17B, 1'b1, 1, 1'b0, -1, 1'b0, "R5 len1 seq");
  endtask

  task automatic testWriteSingle();
    doBurst(mk(3, 0, 1), 9'h0AD, 1'b1, 1, 1'b0, -1, 1'b0, "R7 write single");
    doBurst(mk(3, 0, 1), 9'h0AD, 1'b0, 8, 1'b0, -1, 1'b0, "R7 read keeps length");
  endtask

  task automatic testFullRow();
    doBurst(mk(7, 0, 0), 509, 1'b0, 512, 1'b0, 5, 1'b0, "R6 row wrap and terminate");
  endtask

  task automatic testTerminate();
    doBurst(mk(3, 0, 0), 9'h0AD, 1'b0, 8, 1'b0, 2, 1'b0, "R9 early terminate");
    @(negedge clk);
    terminate = 1'b1;
    @(negedge clk);
    terminate = 1'b0;
    check(colValid === 1'b0, "R9 idle terminate valid", int'(colValid), 0);
    check(burstDone === 1'b0, "R9 idle terminate done", int'(burstDone), 0);
    // terminate on the natural last beat
    doBurst(mk(2, 0, 0), 9'h036, 1'b0, 4, 1'b0, 3, 1'b0, "R8 R9 terminate on last");
  endtask

  task automatic testBusyStart();
    doBurst(mk(2, 1, 0), 9'h0C9, 1'b0, 4, 1'b1, -1, 1'b1, "R10 start while busy");
  endtask

  task automatic testIllegal();
    logic [12:0] bad [8];
    bad[0] = mk(4, 0, 0);
    bad[1] = mk(5, 0, 0);
    bad[2] = mk(6, 0, 0);
    bad[3] = mk(3, 0, 0) & ~13'h070;
    bad[4] = (mk(3, 0, 0) & ~13'h070) | 13'h040;
    bad[5] = mk(3, 0, 0) | 13'h080;
    bad[6] = mk(3, 0, 0) | 13'h400;
    bad[7] = mk(7, 1, 0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      modeWord = bad[i];
      #1;
      check(modeIllegal === 1'b1, "R11 reserved flagged", int'(modeIllegal), 1);
    end
    @(negedge clk);
    modeWord = mk(7, 0, 1);
    #1;
    check(modeIllegal === 1'b0, "R11 legal word", int'(modeIllegal), 0);
    @(negedge clk);
    modeWord = mk(7, 1, 0); startCol = 9'h010; startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    check(colValid === 1'b0, "R11 illegal start refused", int'(colValid), 0);
    @(negedge clk);
    check(burstDone === 1'b0, "R11 no done after refusal", int'(burstDone), 0);
    check(colValid === 1'b0, "R11 still idle", int'(colValid), 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=0", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSequential();
    testInterleaved();
    testSingle();
    testWriteSingle();
    testFullRow();
    testTerminate();
    testBusyStart();
    testIllegal();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule